// File: doc/BRIEF.md
# Command Sequence Write Protector

This block sits in front of the write port of an 8K-byte non-volatile array. It watches every host byte write for short address/data command sequences. For each write it decides in the same cycle whether the byte belongs to a command, loads the block lock mask, or is a normal data write. It then grants or holds back the array write strobe. Two protection layers are kept. The first is a global write-protect flag which, once armed, lets data through only inside a write window opened by the arming sequence. The second is an 8-bit lock mask in which each bit vetoes writes to one 1K-byte block, whatever the state of the first layer.

The host system reports an expired inter-byte load window on `loadTimeout`. That pulse ends any partial command sequence and closes the data window. The retained settings (protect flag and mask) are plain registers with a reset value. The array itself lies outside the block.

Top module: `cmd_seq_wprot`

## Requirements
- R1: After reset `protectOn` is 0, `windowOpen` is 0 and `lockMask` is 8'h00.
- R2: While `protectOn` is 0, a write that is not a command byte and whose block is unlocked raises `arrayWrEn` in the same cycle as `wrReq`.
- R3: The three writes 8'hAA to 12'h555, 8'h55 to 12'hAAA and 8'hA0 to 12'h555 arm the protection. Only address bits [11:0] are compared, so bit 12 is ignored. From the next cycle `protectOn` and `windowOpen` are 1, and the sequence can be given again while already armed.
- R4: While `protectOn` is 1 and `windowOpen` is 0, every write is held back (`arrayWrEn` 0).
- R5: Once opened, the window stays open for any number of writes and closes in the cycle after a `loadTimeout` pulse. `protectOn` is not changed by this.
- R6: The five writes 8'hAA to 12'h555, 8'h55 to 12'hAAA, 8'hC0 to 12'hAAA, 8'hAA to 12'h555 and 8'hA0 to 12'h555 open the lock register. The next write, at any address, loads its data into `lockMask`, taking effect in the following cycle. No other write changes `lockMask`.
- R7: `lockMask` bit k (1 = locked) covers addresses k*1024 to k*1024+1023, so the block index is address bits [12:10]. A write to a locked block never raises `arrayWrEn`, even inside an open window.
- R8: Command bytes and the lock register load never raise `arrayWrEn`.
- R9: A write that does not continue a partial sequence cancels it. That write is judged as an ordinary write under the current protection state.
- R10: A `loadTimeout` pulse cancels a partial sequence. A write in the same cycle as the pulse is judged after the cancellation and with the window already closed.
- R11: Right after the arming sequence, the writes 8'hAA to 12'h555 and then 8'h80 to 12'hAAA clear `protectOn` and close the window from the next cycle.
- R12: The armed state survives timeouts, broken sequences and lock register loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrReq | input | 1 | One-cycle host byte write request |
| wrAddr | input | 13 | Byte address of the write |
| wrData | input | 8 | Byte data of the write |
| loadTimeout | input | 1 | Pulse: inter-byte load window expired |
| arrayWrEn | output | 1 | Permit for the array write of this request |
| lockMask | output | 8 | Current block lock mask, 1 = locked |
| protectOn | output | 1 | Global write protection armed |
| windowOpen | output | 1 | Data write window open under protection |

## Verification
Most internal faults show up as a wrong `arrayWrEn` in the very cycle of a host write. A sequence tracker that is one step off either lets a command byte through or blocks the data byte that follows a correct sequence. Faults in the retained state show on `protectOn`, `windowOpen` or `lockMask` one cycle after the write or timeout that should have changed them. A reference model tracks the received command bytes as a history list and compares it against the three patterns, so disagreements are caught at the first clock where they differ.

// File: rtl/cmd_seq_wprot_pkg.sv
package cmd_seq_wprot_pkg;

  localparam logic [11:0] ADR_LO = 12'h555;
  localparam logic [11:0] ADR_HI = 12'hAAA;
  localparam logic [7:0]  KEY_A  = 8'hAA;
  localparam logic [7:0]  KEY_B  = 8'h55;
  localparam logic [7:0]  KEY_ARM = 8'hA0;
  localparam logic [7:0]  KEY_LOCK = 8'hC0;
  localparam logic [7:0]  KEY_OFF = 8'h80;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_G1,
    SQ_G2,
    SQ_ARMED,
    SQ_OFF4,
    SQ_LK3,
    SQ_LK4,
    SQ_LKREG
  } seqState_e;

  typedef struct packed {
    logic cmdByte;
    logic arm;
    logic disarm;
    logic maskLoad;
    logic closeWin;
  } protStrb_t;

endpackage

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
  import cmd_seq_wprot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  output protStrb_t         strb
);
  localparam int CMD_W = ADDR_W - 1;

  seqState_e state, effState, nextState;
  logic [CMD_W-1:0] cmdAddr;

  assign cmdAddr  = wrAddr[CMD_W-1:0];
  assign effState = loadTimeout ? SQ_IDLE : state;

  function automatic logic hit(input logic [CMD_W-1:0] a, input logic [DATA_W-1:0] d,
                               input logic [11:0] ka, input logic [7:0] kd);
    return (a == CMD_W'(ka)) && (d == DATA_W'(kd));
  endfunction

  always_comb begin
    nextState = effState;
    strb = '0;
    strb.closeWin = loadTimeout;
    if (wrReq) begin
      nextState = SQ_IDLE;
      unique case (effState)
        SQ_IDLE:
          if (hit(cmdAddr, wrData, ADR_LO, KEY_A)) begin
            strb.cmdByte = 1'b1; nextState = SQ_G1;
          end
        SQ_G1:
          if (hit(cmdAddr, wrData, ADR_HI, KEY_B)) begin
            strb.cmdByte = 1'b1; nextState = SQ_G2;
          end
        SQ_G2:
          if (hit(cmdAddr, wrData, ADR_LO, KEY_ARM)) begin
            strb.cmdByte = 1'b1; strb.arm = 1'b1; nextState = SQ_ARMED;
          end else if (hit(cmdAddr, wrData, ADR_HI, KEY_LOCK)) begin
            strb.cmdByte = 1'b1; nextState = SQ_LK3;
          end
        SQ_ARMED:
          if (hit(cmdAddr, wrData, ADR_LO, KEY_A)) begin
            strb.cmdByte = 1'b1; nextState = SQ_OFF4;
          end
        SQ_OFF4:
          if (hit(cmdAddr, wrData, ADR_HI, KEY_OFF)) begin
            strb.cmdByte = 1'b1; strb.disarm = 1'b1;
          end
        SQ_LK3:
          if (hit(cmdAddr, wrData, ADR_LO, KEY_A)) begin
            strb.cmdByte = 1'b1; nextState = SQ_LK4;
          end
        SQ_LK4:
          if (hit(cmdAddr, wrData, ADR_LO, KEY_ARM)) begin
            strb.cmdByte = 1'b1; nextState = SQ_LKREG;
          end
        SQ_LKREG: begin
          strb.cmdByte = 1'b1; strb.maskLoad = 1'b1;
        end
        default: nextState = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nextState;
  end

  // R10: a timeout in the same cycle as a write never lets it load the mask
  assert_timeout_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loadTimeout && wrReq) |-> !strb.maskLoad);

  // R3: arming and disarming never both happen on one byte
  assert_arm_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.arm |-> !strb.disarm);

endmodule

// File: rtl/cmd_seq_dpath.sv
module cmd_seq_dpath
  import cmd_seq_wprot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int BLOCKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  protStrb_t         strb,
  output logic              arrayWrEn,
  output logic [BLOCKS-1:0] lockMask,
  output logic              protectOn,
  output logic              windowOpen
);
  localparam int BLK_W = $clog2(BLOCKS);

  logic [BLK_W-1:0] blkIdx;
  logic             blkLocked;
  logic             winLive;

  assign blkIdx    = wrAddr[ADDR_W-1 -: BLK_W];
  assign blkLocked = lockMask[blkIdx];
  assign winLive   = windowOpen && !strb.closeWin;
  assign arrayWrEn = wrReq && !strb.cmdByte && !blkLocked && (!protectOn || winLive);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protectOn  <= 1'b0;
      windowOpen <= 1'b0;
      lockMask   <= '0;
    end else begin
      if (strb.arm)         protectOn <= 1'b1;
      else if (strb.disarm) protectOn <= 1'b0;
      if (strb.arm)                          windowOpen <= 1'b1;
      else if (strb.disarm || strb.closeWin) windowOpen <= 1'b0;
      if (strb.maskLoad) lockMask <= BLOCKS'(wrData);
    end
  end

  assert_cmd_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cmdByte |-> !arrayWrEn);

  assert_lock_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && lockMask[blkIdx]) |-> !arrayWrEn);

  assert_closed_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && protectOn && !windowOpen) |-> !arrayWrEn);

  assert_timeout_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.closeWin |=> !windowOpen);

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.maskLoad |=> $stable(lockMask));

  assert_window_needs_arm_R12: assert property (@(posedge clk) disable iff (!rst_n)
    windowOpen |-> protectOn);

endmodule

// File: rtl/cmd_seq_wprot.sv
module cmd_seq_wprot
  import cmd_seq_wprot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int BLOCKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  output logic              arrayWrEn,
  output logic [BLOCKS-1:0] lockMask,
  output logic              protectOn,
  output logic              windowOpen
);
  protStrb_t strb;

  cmd_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .loadTimeout(loadTimeout), .strb(strb)
  );

  cmd_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCKS(BLOCKS)) dpath_i (
    .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .strb(strb), .arrayWrEn(arrayWrEn),
    .lockMask(lockMask), .protectOn(protectOn), .windowOpen(windowOpen)
  );

endmodule

// File: tb/cmd_seq_wprot_tb_top.sv
`timescale 1ns/1ps
module cmd_seq_wprot_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrReq = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic loadTimeout = 1'b0;
  logic arrayWrEn, protectOn, windowOpen;
  logic [7:0] lockMask;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  cmd_seq_wprot dut_i (
    .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .loadTimeout(loadTimeout), .arrayWrEn(arrayWrEn), .lockMask(lockMask),
    .protectOn(protectOn), .windowOpen(windowOpen)
  );

  // ---------------- reference model ----------------
  int hA[$];
  int hD[$];
  int armA[5] = '{'h555, 'hAAA, 'h555, 0, 0};
  int armD[5] = '{'hAA, 'h55, 'hA0, 0, 0};
  int offA[5] = '{'h555, 'hAAA, 'h555, 'h555, 'hAAA};
  int offD[5] = '{'hAA, 'h55, 'hA0, 'hAA, 'h80};
  int lckA[5] = '{'h555, 'hAAA, 'hAAA, 'h555, 'h555};
  int lckD[5] = '{'hAA, 'h55, 'hC0, 'hAA, 'hA0};
  bit mProt = 0, mWin = 0;
  int mMask = 0;

  function automatic bit isPfx(int pa[5], int pd[5], int plen);
    if (hA.size() > plen) return 0;
    foreach (hA[i]) if (hA[i] != pa[i] || hD[i] != pd[i]) return 0;
    return 1;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      hA.delete(); hD.delete(); mProt = 0; mWin = 0; mMask = 0;
    end else begin
      bit consumed;
      bit expPermit;
      cmp({curReq, " protectOn"}, protectOn, mProt);
      cmp({curReq, " windowOpen"}, windowOpen, mWin);
      cmp({curReq, " lockMask"}, lockMask, mMask);
      if (loadTimeout) begin hA.delete(); hD.delete(); mWin = 0; end
      expPermit = 0;
      if (wrReq) begin
        consumed = 0;
        if (hA.size() == 5) begin
          mMask = wrData; hA.delete(); hD.delete(); consumed = 1;
        end else begin
          hA.push_back(int'(wrAddr[11:0])); hD.push_back(int'(wrData));
          if (isPfx(armA, armD, 3) || isPfx(offA, offD, 5) || isPfx(lckA, lckD, 5)) begin
            consumed = 1;
            if (hA.size() == 3 && isPfx(armA, armD, 3)) begin mProt = 1; mWin = 1; end
            if (hA.size() == 5 && isPfx(offA, offD, 5)) begin
              mProt = 0; mWin = 0; hA.delete(); hD.delete();
            end
          end else begin
            hA.delete(); hD.delete();
          end
        end
        if (!consumed && !mMask[wrAddr[12:10]] && (!mProt || mWin)) expPermit = 1;
      end
      cmp({curReq, " arrayWrEn"}, arrayWrEn, expPermit);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit to = 0);
    @(posedge clk); #1;
    wrReq = 1'b1; wrAddr = a; wrData = d; loadTimeout = to;
    @(posedge clk); #1;
    wrReq = 1'b0; loadTimeout = 1'b0;
  endtask

  task automatic wrChk(input logic [12:0] a, input logic [7:0] d, input bit exp, input string tag);
    @(posedge clk); #1;
    wrReq = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    cmp({tag, " direct arrayWrEn"}, arrayWrEn, exp);
    @(posedge clk); #1;
    wrReq = 1'b0;
  endtask

  task automatic timeoutPulse();
    @(posedge clk); #1; loadTimeout = 1'b1;
    @(posedge clk); #1; loadTimeout = 1'b0;
  endtask

  task automatic armSeq(input logic [12:0] top);
    wr(top | 13'h555, 8'hAA);
    wr(top | 13'hAAA, 8'h55);
    wr(top | 13'h555, 8'hA0);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    curReq = "R1";
    cmp("R1 reset protectOn", protectOn, 0);
    cmp("R1 reset windowOpen", windowOpen, 0);
    cmp("R1 reset lockMask", lockMask, 0);

    curReq = "R2";
    wrChk(13'h0010, 8'h11, 1, "R2");
    wrChk(13'h1FFF, 8'h22, 1, "R2");

    curReq = "R9";
    wr(13'h0555, 8'hAA);
    wrChk(13'h0123, 8'h34, 1, "R9");
    wr(13'h0555, 8'hAA);
    wrChk(13'h0AAA, 8'h56, 1, "R9");

    curReq = "R10";
    wr(13'h0555, 8'hAA);
    timeoutPulse();
    wrChk(13'h0AAA, 8'h55, 1, "R10");
    wr(13'h0555, 8'hAA);
    wr(13'h0AAA, 8'h55, 1);
    cmp("R10 no arm after aborted seq", protectOn, 0);

    curReq = "R3";
    wr(13'h1555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wrChk(13'h1555, 8'hA0, 0, "R8");
    cmp("R3 protectOn after arm", protectOn, 1);
    cmp("R3 windowOpen after arm", windowOpen, 1);

    curReq = "R5";
    wrChk(13'h0040, 8'h01, 1, "R5");
    wrChk(13'h1040, 8'h02, 1, "R5");
    wrChk(13'h0041, 8'h03, 1, "R5");
    timeoutPulse();
    cmp("R5 window closed", windowOpen, 0);
    cmp("R12 still armed", protectOn, 1);

    curReq = "R4";
    wrChk(13'h0040, 8'h04, 0, "R4");
    wrChk(13'h1800, 8'h05, 0, "R4");

    curReq = "R6";
    wr(13'h0555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h0AAA, 8'hC0);
    wr(13'h0555, 8'hAA);
    wr(13'h0555, 8'hA0);
    wrChk(13'h1234, 8'h05, 0, "R8");
    cmp("R6 mask loaded", lockMask, 8'h05);
    cmp("R12 armed after mask", protectOn, 1);

    curReq = "R7";
    armSeq(13'h0000);
    wrChk(13'h0010, 8'h66, 0, "R7");
    wrChk(13'h0410, 8'h67, 1, "R7");
    wrChk(13'h0800, 8'h68, 0, "R7");
    wrChk(13'h0BFF, 8'h69, 0, "R7");
    wrChk(13'h0C00, 8'h6A, 1, "R7");
    timeoutPulse();

    curReq = "R11";
    armSeq(13'h1000);
    wr(13'h0555, 8'hAA);
    wr(13'h1AAA, 8'h80);
    cmp("R11 protectOn cleared", protectOn, 0);
    cmp("R11 windowOpen cleared", windowOpen, 0);
    wrChk(13'h1C00, 8'h77, 1, "R11");
    wrChk(13'h0000, 8'h78, 0, "R7");

    curReq = "R6";
    wr(13'h0555, 8'hAA);
    wr(13'h0AAA, 8'h55);
    wr(13'h0AAA, 8'hC0);
    wr(13'h0555, 8'hAA);
    wr(13'h0555, 8'hA0);
    wr(13'h0000, 8'h00);
    cmp("R6 mask cleared", lockMask, 0);
    wrChk(13'h0000, 8'h79, 1, "R2");

    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule